// File: doc/BRIEF.md
# Miscellaneous Integer Operation Unit

This unit is a purely combinational 32-bit execution slice. It handles the auxiliary integer operations of a processor datapath. Three 32-bit values come in: a first operand, a second operand and the present value of the destination register. An operation select and two 4-bit immediate fields are given alongside them. The unit returns one 32-bit result in the same cycle.

The slice covers eight kinds of work. Sign extension and saturation work from a variable bit position. There are signed and unsigned minimum and maximum, conditional moves keyed on the second operand, negation and absolute value, and add or subtract with a pre-scaled first operand. It also multiplies the low halves of the two operands and extracts an unsigned bit field. Register access, instruction decode and exception handling belong to the surrounding pipeline. That pipeline receives an illegal flag whenever the select value names no operation.

Top module: `misc_int_unit`

## Requirements
- R1: Select 0 (sign extend) returns operand A with bit (T+7) copied into every bit above it, where T is the 4-bit field `fld_t`; the bits from (T+7) down to 0 pass unchanged.
- R2: Select 1 (clamp) returns A unchanged when it lies in the signed (T+8)-bit range. Otherwise it returns -2^(T+7) for a negative A or 2^(T+7)-1 for a positive A.
- R3: Selects 2, 3, 4 and 5 return the signed minimum, signed maximum, unsigned minimum and unsigned maximum of A and B, in that order.
- R4: Selects 8, 9, 10 and 11 copy A to the result when B is zero, nonzero, negative or non-negative, in that order. When the condition does not hold they return the old destination value.
- R5: Select 6 returns the two's-complement negation of A.
- R6: Select 7 returns A when A is non-negative and its negation otherwise. For A = 0x80000000 the result is 0x80000000.
- R7: Selects 12, 13 and 14 return (A<<1)+B, (A<<2)+B and (A<<3)+B. Selects 15, 16 and 17 return (A<<1)-B, (A<<2)-B and (A<<3)-B. All results are taken modulo 2^32.
- R8: Select 18 returns the product of the zero-extended low 16 bits of A and B. Select 19 returns the product of the sign-extended low 16 bits. The result is the low 32 bits of the product.
- R9: Selects 20 and 21 shift A right logically by {sel[0]==1 for 21, `fld_s`} (a 5-bit amount, where select 21 sets bit 4). They then keep the low (T+1) bits and clear the rest.
- R10: Selects 22 to 31 return zero and raise `illegal`; every select from 0 to 21 leaves `illegal` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand, also the test value of the conditional moves |
| dest_old | input | 32 | Current destination value, kept by a failed conditional move |
| op_sel | input | 5 | Operation select |
| fld_t | input | 4 | Position / width field |
| fld_s | input | 4 | Low four bits of the extract shift |
| result | output | 32 | Operation result |
| illegal | output | 1 | Select names no operation |

## Verification
The saturating clamp is the hardest behaviour to reach. Its boundary moves with the width field, so a single pattern only ever tests one of sixteen thresholds. The stimulus therefore sweeps every width. At each one it applies the four values that sit on either side of the upper and lower limits. The same sweep drives sign extension at every position. The absolute value of the most negative number and the extract shift past bit 15 are applied as directed vectors.

// File: rtl/misc_int_pkg.sv
package misc_int_pkg;
  localparam int DW  = 32;
  localparam int OPW = 5;
  localparam int FW  = 4;
  localparam int POS_BASE = 7;
  localparam int HALF = DW / 2;

  typedef enum logic [OPW-1:0] {
    OP_SEXT  = 5'd0,  OP_CLAMP = 5'd1,
    OP_MIN   = 5'd2,  OP_MAX   = 5'd3,  OP_MINU  = 5'd4,  OP_MAXU = 5'd5,
    OP_NEG   = 5'd6,  OP_ABS   = 5'd7,
    OP_MVEQZ = 5'd8,  OP_MVNEZ = 5'd9,  OP_MVLTZ = 5'd10, OP_MVGEZ = 5'd11,
    OP_ADD2  = 5'd12, OP_ADD4  = 5'd13, OP_ADD8  = 5'd14,
    OP_SUB2  = 5'd15, OP_SUB4  = 5'd16, OP_SUB8  = 5'd17,
    OP_MULU  = 5'd18, OP_MULS  = 5'd19,
    OP_EXTLO = 5'd20, OP_EXTHI = 5'd21
  } op_e;

  // Copy the bit at position t+POS_BASE into all higher bits.
  function automatic logic [DW-1:0] sext_from(input logic [DW-1:0] v,
                                              input logic [FW-1:0] t);
    logic [DW-1:0] r;
    int p;
    p = int'(t) + POS_BASE;
    for (int i = 0; i < DW; i++) r[i] = (i > p) ? v[p] : v[i];
    return r;
  endfunction

  // Saturate to the signed range of t+POS_BASE+1 bits.
  function automatic logic [DW-1:0] clamp_to(input logic [DW-1:0] v,
                                             input logic [FW-1:0] t);
    logic [DW-1:0] r;
    logic fits;
    int p;
    p = int'(t) + POS_BASE;
    fits = 1'b1;
    for (int i = 0; i < DW; i++)
      if (i > p && v[i] != v[p]) fits = 1'b0;
    for (int i = 0; i < DW; i++)
      r[i] = fits ? v[i] : ((i >= p) ? v[DW-1] : ~v[DW-1]);
    return r;
  endfunction

  function automatic logic [DW-1:0] field_of(input logic [DW-1:0] v,
                                             input logic [FW:0]   sh,
                                             input logic [FW-1:0] w);
    logic [DW-1:0] m;
    m = {DW{1'b1}} >> (DW - 1 - int'(w));
    return (v >> sh) & m;
  endfunction

  function automatic logic [DW-1:0] mul_low(input logic [DW-1:0] a,
                                            input logic [DW-1:0] b,
                                            input logic sgn);
    logic [DW-1:0] ea, eb;
    ea = {{HALF{sgn & a[HALF-1]}}, a[HALF-1:0]};
    eb = {{HALF{sgn & b[HALF-1]}}, b[HALF-1:0]};
    return ea * eb;
  endfunction
endpackage

// File: rtl/misc_field_unit.sv
module misc_field_unit
  import misc_int_pkg::*;
(
  input  logic [DW-1:0]  opnd_a,
  input  op_e            op,
  input  logic [FW-1:0]  fld_t,
  input  logic [FW-1:0]  fld_s,
  output logic [DW-1:0]  fld_res,
  output logic           fld_hit
);
  logic [FW:0]   ext_shift;
  logic [DW-1:0] sext_w, clamp_w, ext_w;
  logic signed [DW:0] clamp_hi, clamp_lo;

  assign ext_shift = {op == OP_EXTHI, fld_s};
  assign sext_w  = sext_from(opnd_a, fld_t);
  assign clamp_w = clamp_to(opnd_a, fld_t);
  assign ext_w   = field_of(opnd_a, ext_shift, fld_t);
  assign clamp_hi = (DW+1)'(1) <<< (int'(fld_t) + POS_BASE);
  assign clamp_lo = -clamp_hi;

  always_comb begin
    fld_hit = 1'b1;
    case (op)
      OP_SEXT:            fld_res = sext_w;
      OP_CLAMP:           fld_res = clamp_w;
      OP_EXTLO, OP_EXTHI: fld_res = ext_w;
      default: begin
        fld_res = '0;
        fld_hit = 1'b0;
      end
    endcase
  end

  always_comb begin
    // R1
    sext_upper_chk: assert ($countones(sext_w >> (int'(fld_t) + POS_BASE)) == 0 ||
                            (sext_w >> (int'(fld_t) + POS_BASE)) ==
                            ({DW{1'b1}} >> (int'(fld_t) + POS_BASE)))
      else $error("sign extension upper bits not uniform");
    // R2
    clamp_range_chk: assert ($signed({clamp_w[DW-1], clamp_w}) < clamp_hi &&
                             $signed({clamp_w[DW-1], clamp_w}) >= clamp_lo)
      else $error("clamp result out of range");
    // R9
    ext_width_chk: assert ((ext_w >> (int'(fld_t) + 1)) == '0)
      else $error("extract result wider than field");
  end
endmodule

// File: rtl/misc_arith_unit.sv
module misc_arith_unit
  import misc_int_pkg::*;
(
  input  logic [DW-1:0] opnd_a,
  input  logic [DW-1:0] opnd_b,
  input  logic [DW-1:0] dest_old,
  input  op_e           op,
  output logic [DW-1:0] ar_res,
  output logic          ar_hit,
  output logic          mv_taken
);
  localparam logic [DW-1:0] MOST_NEG = {1'b1, {(DW-1){1'b0}}};

  logic       lt_s, lt_u, a_less, pick_a;
  logic [1:0] mm_idx;
  logic       b_zero, b_neg;
  logic [DW-1:0] neg_a, abs_a;

  assign lt_s   = $signed(opnd_a) < $signed(opnd_b);
  assign lt_u   = opnd_a < opnd_b;
  assign mm_idx = 2'(op - OP_MIN);
  assign a_less = mm_idx[1] ? lt_u : lt_s;
  assign pick_a = mm_idx[0] ? !a_less : a_less;
  assign b_zero = (opnd_b == '0);
  assign b_neg  = opnd_b[DW-1];
  assign neg_a  = '0 - opnd_a;
  assign abs_a  = opnd_a[DW-1] ? neg_a : opnd_a;

  always_comb begin
    case (op)
      OP_MVEQZ: mv_taken = b_zero;
      OP_MVNEZ: mv_taken = !b_zero;
      OP_MVLTZ: mv_taken = b_neg;
      OP_MVGEZ: mv_taken = !b_neg;
      default:  mv_taken = 1'b0;
    endcase
  end

  always_comb begin
    ar_hit = 1'b1;
    case (op)
      OP_MIN, OP_MAX, OP_MINU, OP_MAXU: ar_res = pick_a ? opnd_a : opnd_b;
      OP_NEG: ar_res = neg_a;
      OP_ABS: ar_res = abs_a;
      OP_MVEQZ, OP_MVNEZ, OP_MVLTZ, OP_MVGEZ:
        ar_res = mv_taken ? opnd_a : dest_old;
      OP_ADD2: ar_res = (opnd_a << 1) + opnd_b;
      OP_ADD4: ar_res = (opnd_a << 2) + opnd_b;
      OP_ADD8: ar_res = (opnd_a << 3) + opnd_b;
      OP_SUB2: ar_res = (opnd_a << 1) - opnd_b;
      OP_SUB4: ar_res = (opnd_a << 2) - opnd_b;
      OP_SUB8: ar_res = (opnd_a << 3) - opnd_b;
      OP_MULU: ar_res = mul_low(opnd_a, opnd_b, 1'b0);
      OP_MULS: ar_res = mul_low(opnd_a, opnd_b, 1'b1);
      default: begin
        ar_res = '0;
        ar_hit = 1'b0;
      end
    endcase
  end

  always_comb begin
    // R3
    minmax_pick_chk: assert (!(op inside {OP_MIN, OP_MAX, OP_MINU, OP_MAXU}) ||
                             ar_res == opnd_a || ar_res == opnd_b)
      else $error("min/max returned neither operand");
    // R6
    abs_sign_chk: assert (op != OP_ABS || !ar_res[DW-1] || opnd_a == MOST_NEG)
      else $error("absolute value negative");
    // R4
    mv_hold_chk: assert (!(op inside {OP_MVEQZ, OP_MVNEZ, OP_MVLTZ, OP_MVGEZ}) ||
                         mv_taken || ar_res == dest_old)
      else $error("failed conditional move altered destination");
  end
endmodule

// File: rtl/misc_int_unit.sv
module misc_int_unit
  import misc_int_pkg::*;
(
  input  logic [31:0] opnd_a,
  input  logic [31:0] opnd_b,
  input  logic [31:0] dest_old,
  input  logic [4:0]  op_sel,
  input  logic [3:0]  fld_t,
  input  logic [3:0]  fld_s,
  output logic [31:0] result,
  output logic        illegal
);
  op_e           op;
  logic [DW-1:0] fld_res, ar_res;
  logic          fld_hit, ar_hit, mv_taken;

  assign op = op_e'(op_sel);

  misc_field_unit u_field (
    .opnd_a (opnd_a),
    .op     (op),
    .fld_t  (fld_t),
    .fld_s  (fld_s),
    .fld_res(fld_res),
    .fld_hit(fld_hit)
  );

  misc_arith_unit u_arith (
    .opnd_a  (opnd_a),
    .opnd_b  (opnd_b),
    .dest_old(dest_old),
    .op      (op),
    .ar_res  (ar_res),
    .ar_hit  (ar_hit),
    .mv_taken(mv_taken)
  );

  assign illegal = !(fld_hit || ar_hit);
  assign result  = fld_hit ? fld_res : (ar_hit ? ar_res : '0);

  always_comb begin
    // R10
    one_owner_chk: assert ($onehot0({fld_hit, ar_hit}))
      else $error("two sub-units claim one select");
    // R10
    illegal_zero_chk: assert (!illegal || (result == '0 && op_sel > 5'd21))
      else $error("illegal select with nonzero result or legal code");
  end
endmodule

// File: tb/misc_int_unit_test.sv
module misc_int_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 24;
  localparam int VW = 5 + 4 + 4 + 32 * 4;

  // {op, t, s, a, b, d, expected}
  localparam logic [VW-1:0] VEC [NVEC] = '{
    {5'd0, 4'd0, 4'd0, 32'h00000080, 32'h0, 32'h0, 32'hFFFFFF80},  // R1
    {5'd0, 4'd8, 4'd0, 32'h12347FFF, 32'h0, 32'h0, 32'h00007FFF},  // R1
    {5'd0, 4'd15,4'd0, 32'h00400000, 32'h0, 32'h0, 32'hFFC00000},  // R1
    {5'd1, 4'd0, 4'd0, 32'h00000100, 32'h0, 32'h0, 32'h0000007F},  // R2
    {5'd1, 4'd0, 4'd0, 32'hFFFFFF00, 32'h0, 32'h0, 32'hFFFFFF80},  // R2
    {5'd1, 4'd0, 4'd0, 32'hFFFFFF85, 32'h0, 32'h0, 32'hFFFFFF85},  // R2
    {5'd2, 4'd0, 4'd0, 32'hFFFFFFFF, 32'h1, 32'h0, 32'hFFFFFFFF},  // R3
    {5'd3, 4'd0, 4'd0, 32'hFFFFFFFF, 32'h1, 32'h0, 32'h00000001},  // R3
    {5'd4, 4'd0, 4'd0, 32'hFFFFFFFF, 32'h1, 32'h0, 32'h00000001},  // R3
    {5'd5, 4'd0, 4'd0, 32'hFFFFFFFF, 32'h1, 32'h0, 32'hFFFFFFFF},  // R3
    {5'd8, 4'd0, 4'd0, 32'hAAAA0000, 32'h0, 32'h11, 32'hAAAA0000}, // R4
    {5'd9, 4'd0, 4'd0, 32'hAAAA0000, 32'h0, 32'h11, 32'h00000011}, // R4
    {5'd10,4'd0, 4'd0, 32'hAAAA0000, 32'h80000000, 32'h11, 32'hAAAA0000}, // R4
    {5'd11,4'd0, 4'd0, 32'hAAAA0000, 32'h80000000, 32'h11, 32'h00000011}, // R4
    {5'd6, 4'd0, 4'd0, 32'h00000005, 32'h0, 32'h0, 32'hFFFFFFFB},  // R5
    {5'd7, 4'd0, 4'd0, 32'hFFFFFFFB, 32'h0, 32'h0, 32'h00000005},  // R6
    {5'd7, 4'd0, 4'd0, 32'h80000000, 32'h0, 32'h0, 32'h80000000},  // R6
    {5'd13,4'd0, 4'd0, 32'h00000003, 32'd10, 32'h0, 32'h00000016}, // R7
    {5'd17,4'd0, 4'd0, 32'h00000002, 32'd20, 32'h0, 32'hFFFFFFFC}, // R7
    {5'd18,4'd0, 4'd0, 32'h1234FFFF, 32'hABCD0002, 32'h0, 32'h0001FFFE}, // R8
    {5'd19,4'd0, 4'd0, 32'h1234FFFF, 32'hABCD0002, 32'h0, 32'hFFFFFFFE}, // R8
    {5'd20,4'd7, 4'd4, 32'h12345678, 32'h0, 32'h0, 32'h00000067},  // R9
    {5'd21,4'd3, 4'd12,32'hA0000000, 32'h0, 32'h0, 32'h0000000A},  // R9
    {5'd25,4'd0, 4'd0, 32'hFFFFFFFF, 32'h1, 32'h5, 32'h00000000}   // R10
  };

  logic clk = 1'b0;
  logic [31:0] opnd_a, opnd_b, dest_old, result;
  logic [4:0]  op_sel;
  logic [3:0]  fld_t, fld_s;
  logic        illegal;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  misc_int_unit uut (
    .opnd_a(opnd_a), .opnd_b(opnd_b), .dest_old(dest_old),
    .op_sel(op_sel), .fld_t(fld_t), .fld_s(fld_s),
    .result(result), .illegal(illegal)
  );

  task automatic apply(input logic [4:0] op, input logic [3:0] t,
                       input logic [3:0] s, input logic [31:0] a,
                       input logic [31:0] b, input logic [31:0] d);
    @(posedge clk);
    op_sel = op; fld_t = t; fld_s = s; opnd_a = a; opnd_b = b; dest_old = d;
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] got,
                       input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [31:0] ref_sext(input logic [31:0] a, input int t);
    int sh = 24 - t;
    return 32'($signed(a << sh) >>> sh);
  endfunction

  function automatic logic [31:0] ref_clamp(input logic [31:0] a, input int t);
    longint v  = longint'($signed(a));
    longint hi = (longint'(1) << (t + 7)) - 1;
    longint lo = -(longint'(1) << (t + 7));
    if (v > hi) return 32'(hi);
    if (v < lo) return 32'(lo);
    return a;
  endfunction

  initial begin
    op_sel = '0; fld_t = '0; fld_s = '0;
    opnd_a = '0; opnd_b = '0; dest_old = '0;
    @(negedge clk);
    // idle state: select 0 on zero operands
    check("R1 idle result", result, 32'h0);
    check("R10 idle flag", {31'b0, illegal}, 32'h0);

    for (int i = 0; i < NVEC; i++) begin
      logic [VW-1:0] v = VEC[i];
      apply(v[140:136], v[135:132], v[131:128], v[127:96], v[95:64], v[63:32]);
      check($sformatf("vector %0d (sel %0d) R1..R10", i, v[140:136]), result, v[31:0]);
    end

    // width sweep at every clamp threshold and sign position
    for (int t = 0; t < 16; t++) begin
      logic [31:0] edge_v [4];
      edge_v[0] = (32'd1 << (t + 7)) - 1;
      edge_v[1] = (32'd1 << (t + 7));
      edge_v[2] = -(32'd1 << (t + 7));
      edge_v[3] = -(32'd1 << (t + 7)) - 1;
      for (int k = 0; k < 4; k++) begin
        apply(5'd1, 4'(t), 4'd0, edge_v[k], 32'h0, 32'h0);
        check($sformatf("R2 clamp t=%0d k=%0d", t, k), result, ref_clamp(edge_v[k], t));
        apply(5'd0, 4'(t), 4'd0, edge_v[k] ^ 32'h5A000000, 32'h0, 32'h0);
        check($sformatf("R1 sext t=%0d k=%0d", t, k), result,
              ref_sext(edge_v[k] ^ 32'h5A000000, t));
      end
    end

    // R9 full-width field from the top half
    apply(5'd21, 4'd15, 4'd0, 32'hBEEF1234, 32'h0, 32'h0);
    check("R9 shift 16 width 16", result, 32'h0000BEEF);
    // R7 scaled add wraps
    apply(5'd14, 4'd0, 4'd0, 32'h20000001, 32'h7, 32'h0);
    check("R7 add8 wrap", result, 32'h0000000F);

    // R10 flag across all selects
    for (int op = 0; op < 32; op++) begin
      apply(5'(op), 4'd2, 4'd1, 32'h0F0F0F0F, 32'h3, 32'h9);
      check($sformatf("R10 flag sel %0d", op), {31'b0, illegal}, {31'b0, op > 21});
      if (op > 21) check($sformatf("R10 zero sel %0d", op), result, 32'h0);
    end

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule